// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block drives a three-wire serial configuration EEPROM through a select line, a serial clock, a data line towards the device and a data line back from it. A requester hands over an address on a valid/ready request channel. The block then runs one read frame: it raises select, sends a start-and-read command followed by the address, clocks in a 16-bit word and drops select. It returns the word with a one-cycle response pulse. The serial clock comes from the system clock. Each half-period lasts `SK_HALF` system cycles.

Some devices take a 6-bit address and others an 8-bit one. The block keeps a width flag that a parameter presets at reset, so reads work before any sizing is done. A sizing request reads the top location using an 8-bit frame. It records every sample taken during that frame and sets the width flag from one fixed sample position. A 6-bit device drives its leading dummy zero at that position, while an 8-bit device is still taking address bits and leaves the line high.

Back-pressure rules: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The requester holds the request and its fields until then. `req_ready` is low from acceptance through the response cycle. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_data` stays unchanged until the next request is accepted.

Top module: `serial_rom_reader`

## Requirements
- R1: `ee_sel` rises on the acceptance edge. It stays high for 2·SK_HALF cycles before the first rise of `ee_clk` and stays high through the whole frame. It falls SK_HALF cycles after the last fall of `ee_clk`, in the cycle where `rsp_valid` is high. `ee_clk` is never high while `ee_sel` is low.
- R2: The frame starts with the command bits 1, 1, 0 in that order, followed by the address, MSB first. One bit is presented on `ee_tx` per serial clock pulse, and `ee_tx` is low during the data phase.
- R3: With the width flag at 1, the address field is 8 bits (an 11-bit command). With the flag at 0, the field is the low 6 bits of the address (a 9-bit command). Bits of `req_addr` above bit 7 are ignored.
- R4: Each low phase and each high phase of `ee_clk` within the frame lasts SK_HALF system cycles. `ee_tx` does not change while `ee_clk` is high.
- R5: After the command, exactly 16 further pulses are issued, so a frame has 27 pulses (8-bit) or 25 pulses (6-bit). `ee_rx` is sampled at the end of each high phase. The last 16 samples form `rsp_data`, with the first of them in bit 15.
- R6: A sizing request (`req_probe`=1) reads address 255 with an 8-bit frame, whatever the flag holds. Every one of the 27 samples is recorded, the last one in bit 0. `addr_wide` takes recorded bit 18 (the 9th sample) and changes only in the response cycle of a sizing request.
- R7: During and right after reset: `addr_wide` = WIDE_DEFAULT, `ee_sel`/`ee_clk`/`ee_tx` low, `req_ready` high, `busy` low and `rsp_valid` low.
- R8: `rsp_valid` is high for exactly one cycle, SK_HALF·(2N+2) cycles after the acceptance edge, where N is the number of pulses in the frame.
- R9: `busy` is the complement of `req_ready`. A request presented while busy, including in the response cycle, starts no frame. A request held through the response cycle is accepted on the next cycle and uses the width flag as just updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Word address; only bits 7:0 are used |
| req_probe | input | 1 | 1 = sizing request instead of a read |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Word read in the last frame |
| busy | output | 1 | A frame or its response cycle is in progress |
| addr_wide | output | 1 | Current address width flag: 1 = 8 bits, 0 = 6 bits |
| ee_sel | output | 1 | Device select |
| ee_clk | output | 1 | Serial clock to the device |
| ee_tx | output | 1 | Serial data to the device |
| ee_rx | input | 1 | Serial data from the device |

## Verification
Two functions can land on the same cycle: completing a sizing frame (the response pulse together with the change of the width flag) and a new request already waiting at the edge. The bench provokes this by raising a read request while the sizing frame is running and holding it until it is taken. It judges the outcome by three observations: `req_ready` is low in the response cycle, the flag already holds its new value there, and the follow-up frame, seen by a device model in the bench, has the pulse count and address field of the new width. A separate scenario offers requests throughout a busy frame and checks that the device sees exactly one frame.

// File: rtl/mw_rom_pkg.sv
package mw_rom_pkg;
  localparam int DATA_BITS   = 16;
  localparam int ADDR_NARROW = 6;
  localparam int ADDR_WIDE   = 8;
  localparam int OPC_BITS    = 3;
  localparam logic [OPC_BITS-1:0] READ_OPC = 3'b110;
  localparam int CMD_MAX     = OPC_BITS + ADDR_WIDE;
  localparam int FRAME_MAX   = CMD_MAX + DATA_BITS;
  localparam int FRAME_MIN   = OPC_BITS + ADDR_NARROW + DATA_BITS;
  localparam int CNT_W       = $clog2(FRAME_MAX + 1);
  localparam logic [ADDR_WIDE-1:0] PROBE_ADDR = '1;
  localparam int PROBE_BIT   = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R4: while running and not at the end of a phase, the count advances by one
  assert_phase_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt == $past(cnt) + 1'b1) || !run);
endmodule

// File: rtl/mw_cmd_shift.sv
module mw_cmd_shift
  import mw_rom_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 wide,
  input  logic [ADDR_WIDE-1:0] addr,
  input  logic                 shift,
  output logic                 bit_out
);
  localparam int PAD = ADDR_WIDE - ADDR_NARROW;

  logic [CMD_MAX-1:0] sr;
  logic [CMD_MAX-1:0] load_word;

  always_comb begin
    if (wide) load_word = {READ_OPC, addr};
    else      load_word = {READ_OPC, addr[ADDR_NARROW-1:0], {PAD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= load_word;
    else if (shift)  sr <= {sr[CMD_MAX-2:0], 1'b0};
  end

  assign bit_out = sr[CMD_MAX-1];

  // R2: a loaded command always begins with the start bit
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bit_out);
endmodule

// File: rtl/mw_rx_capture.sv
module mw_rx_capture
  import mw_rom_pkg::*;
#(
  parameter int W = FRAME_MAX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw <= '0;
    else if (clr)     raw <= '0;
    else if (sample)  raw <= {raw[W-2:0], din};
  end

  // R5: clearing and sampling come from different phases of the frame
  assert_clr_vs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && sample));
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
  import mw_rom_pkg::*;
#(
  parameter int SK_HALF      = 4,
  parameter int ADDR_W       = 16,
  parameter bit WIDE_DEFAULT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_probe,
  output logic                 rsp_valid,
  output logic [DATA_BITS-1:0] rsp_data,
  output logic                 busy,
  output logic                 addr_wide,
  output logic                 ee_sel,
  output logic                 ee_clk,
  output logic                 ee_tx,
  input  logic                 ee_rx
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(FRAME_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(FRAME_MIN - 1);

  seq_state_t             st;
  logic                   accept;
  logic                   run;
  logic                   tick;
  logic                   frame_wide;
  logic                   probe_op;
  logic [CNT_W-1:0]       bit_idx;
  logic [CNT_W-1:0]       last_idx;
  logic                   bit_end;
  logic                   load_wide;
  logic [ADDR_WIDE-1:0]   load_addr;
  logic                   cmd_bit;
  logic [FRAME_MAX-1:0]   raw;

  assign accept    = req_valid && req_ready;
  assign run       = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH) || (st == ST_HOLD);
  assign bit_end   = (st == ST_HIGH) && tick;
  assign last_idx  = frame_wide ? LAST_WIDE : LAST_NARROW;
  assign load_wide = req_probe || addr_wide;
  assign load_addr = req_probe ? PROBE_ADDR : req_addr[ADDR_WIDE-1:0];

  generate
    if (ADDR_W > ADDR_WIDE) begin : g_hi_unused
      logic unused_addr_hi;
      assign unused_addr_hi = ^req_addr[ADDR_W-1:ADDR_WIDE];
    end
  endgenerate

  logic unused_raw;
  assign unused_raw = ^{raw[FRAME_MAX-1:PROBE_BIT+1], raw[PROBE_BIT-1:DATA_BITS]};

  mw_half_timer #(.HALF(SK_HALF)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  mw_cmd_shift u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .wide    (load_wide),
    .addr    (load_addr),
    .shift   (bit_end),
    .bit_out (cmd_bit)
  );

  mw_rx_capture #(.W(FRAME_MAX)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .sample (bit_end),
    .din    (ee_rx),
    .raw    (raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bit_idx    <= '0;
      frame_wide <= 1'b0;
      probe_op   <= 1'b0;
      addr_wide  <= WIDE_DEFAULT;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st         <= ST_SETUP;
            bit_idx    <= '0;
            frame_wide <= load_wide;
            probe_op   <= req_probe;
          end
        end
        ST_SETUP: if (tick) st <= ST_LOW;
        ST_LOW:   if (tick) st <= ST_HIGH;
        ST_HIGH: begin
          if (tick) begin
            if (bit_idx == last_idx) begin
              st <= ST_HOLD;
            end else begin
              st      <= ST_LOW;
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            st <= ST_DONE;
            if (probe_op) addr_wide <= raw[PROBE_BIT];
          end
        end
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = !req_ready;
  assign rsp_valid = (st == ST_DONE);
  assign rsp_data  = raw[DATA_BITS-1:0];
  assign ee_sel    = run;
  assign ee_clk    = (st == ST_HIGH);
  assign ee_tx     = ((st == ST_LOW) || (st == ST_HIGH)) && cmd_bit;

  // R1: the serial clock only pulses inside a select window
  assert_clk_within_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ee_clk |-> ee_sel);

  // R1: select falls straight into the response cycle
  assert_sel_drop_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sel) |-> rsp_valid);

  // R4: data towards the device holds while the clock is high
  assert_tx_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_clk |-> $stable(ee_tx));

  // R8: the response is a single-cycle pulse
  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6: the width flag moves only in a response cycle
  assert_width_moves_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_wide) |-> rsp_valid);

  // R9: a frame only begins after a handshake
  assert_frame_needs_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sel) |-> $past(req_valid && req_ready));
endmodule

// File: tb/serial_rom_reader_test.sv
`timescale 1ns/1ps
module serial_rom_reader_test;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_probe = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        busy;
  logic        addr_wide;
  logic        ee_sel, ee_clk, ee_tx;
  logic        ee_rx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  serial_rom_reader #(.SK_HALF(HALF), .ADDR_W(16), .WIDE_DEFAULT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_probe(req_probe),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .addr_wide(addr_wide),
    .ee_sel(ee_sel), .ee_clk(ee_clk), .ee_tx(ee_tx), .ee_rx(ee_rx)
  );

  // ---------------- device model ----------------
  int          model_aw = 8;
  logic        model_do = 1'b1;
  int          kcnt = 0;
  logic [10:0] rxsh = '0;
  logic [2:0]  got_op = '0;
  logic [7:0]  got_addr = '0;
  logic [15:0] mword_r = '0;
  int          pulses_last = 0;
  int          frames = 0;

  assign ee_rx = model_do;

  function automatic logic [15:0] mword(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  always @(posedge ee_clk or negedge ee_sel) begin
    if (!ee_sel) begin
      pulses_last = kcnt;
      frames      = frames + 1;
      kcnt        = 0;
      model_do    = 1'b1;
      rxsh        = '0;
    end else begin
      int k;
      int nc;
      logic [10:0] full;
      k    = kcnt + 1;
      kcnt = k;
      nc   = 3 + model_aw;
      full = {rxsh[9:0], ee_tx};
      rxsh = full;
      if (k < nc) model_do = 1'b1;
      else if (k == nc) begin
        model_do = 1'b0;
        if (model_aw == 8) begin
          got_op = full[10:8]; got_addr = full[7:0];
        end else begin
          got_op = full[8:6];  got_addr = {2'b00, full[5:0]};
        end
        mword_r = mword(got_addr);
      end else if (k <= nc + 16) model_do = mword_r[15 - (k - nc - 1)];
      else model_do = 1'b1;
    end
  end

  // ---------------- waveform monitor ----------------
  int   viol_sel = 0, viol_tx = 0;
  int   hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  int   lead = 0, last_lead = 0, tail = 0, last_tail = 0;
  logic prev_clk = 1'b0, prev_tx = 1'b0, prev_sel = 1'b0, seen_clk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_clk && !ee_sel) viol_sel++;
      if (ee_clk && prev_clk && (ee_tx != prev_tx)) viol_tx++;
      if (ee_clk) begin
        hi_run++;
        if (lo_run != 0) begin last_lo = lo_run; lo_run = 0; end
        if (!seen_clk) begin last_lead = lead; seen_clk = 1'b1; end
        tail = 0;
      end else begin
        if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
        if (ee_sel && seen_clk) begin lo_run++; tail++; end
        if (ee_sel && !seen_clk) lead++;
      end
      if (prev_sel && !ee_sel) begin
        last_tail = tail; tail = 0; lo_run = 0; lead = 0; seen_clk = 1'b0;
      end
      prev_clk = ee_clk; prev_tx = ee_tx; prev_sel = ee_sel;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- helpers ----------------
  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic run_req(input logic [15:0] a, input logic pr,
                         output logic [15:0] d, output int lat);
    int c0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_probe = pr;
    while (!req_ready) @(negedge clk);
    c0 = cyc;
    @(negedge clk);
    req_valid = 1'b0; req_probe = 1'b0;
    while (!rsp_valid) @(negedge clk);
    lat = cyc - (c0 + 1);
    d   = rsp_data;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(addr_wide == 1'b1, "R7 wide flag in reset", addr_wide, 1);
    check({ee_sel, ee_clk, ee_tx} == 3'b000, "R7 serial pins in reset", {ee_sel, ee_clk, ee_tx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !rsp_valid, "R7 idle after reset",
          {req_ready, busy, rsp_valid}, 3'b100);
  endtask

  task automatic t_read_wide();
    logic [15:0] d; int lat;
    model_aw = 8;
    run_req(16'h003C, 1'b0, d, lat);
    check(d == mword(8'h3C), "R5 wide read data", d, mword(8'h3C));
    check(lat == HALF * (2 * 27 + 2), "R8 wide latency", lat, HALF * 56);
    @(negedge clk);
    check(!rsp_valid, "R8 pulse length", rsp_valid, 0);
    check(got_op == 3'b110, "R2 opcode bits", got_op, 3'b110);
    check(got_addr == 8'h3C, "R3 wide address", got_addr, 8'h3C);
    check(pulses_last == 27, "R5 wide pulse count", pulses_last, 27);
    check(last_hi == HALF && last_lo == HALF, "R4 phase lengths",
          {last_hi[7:0], last_lo[7:0]}, {HALF[7:0], HALF[7:0]});
    check(last_lead == 2 * HALF && last_tail == HALF, "R1 select lead and tail",
          {last_lead[7:0], last_tail[7:0]}, {8'(2 * HALF), HALF[7:0]});
    check(viol_sel == 0 && viol_tx == 0, "R1 R4 waveform rules",
          {viol_sel[7:0], viol_tx[7:0]}, 0);
  endtask

  task automatic t_upper_bits();
    logic [15:0] d; int lat;
    run_req(16'hA5C3, 1'b0, d, lat);
    check(got_addr == 8'hC3, "R3 upper address bits ignored", got_addr, 8'hC3);
    check(d == mword(8'hC3), "R5 data for masked address", d, mword(8'hC3));
  endtask

  task automatic t_probe_narrow();
    logic [15:0] d; int lat;
    model_aw = 6;
    run_req(16'h0012, 1'b1, d, lat);
    check(addr_wide == 1'b0, "R6 narrow device detected in done cycle", addr_wide, 0);
    check(pulses_last == 27, "R6 probe uses 8-bit frame", pulses_last, 27);
  endtask

  task automatic t_read_narrow();
    logic [15:0] d; int lat;
    run_req(16'h00F7, 1'b0, d, lat);
    check(got_op == 3'b110, "R2 opcode narrow", got_op, 3'b110);
    check(got_addr == 8'h37, "R3 low six address bits", got_addr, 8'h37);
    check(d == mword(8'h37), "R5 narrow read data", d, mword(8'h37));
    check(lat == HALF * (2 * 25 + 2), "R8 narrow latency", lat, HALF * 52);
    check(pulses_last == 25, "R5 narrow pulse count", pulses_last, 25);
  endtask

  task automatic t_busy_ignore();
    int f0; int bad;
    logic [15:0] d;
    f0 = frames; bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0021; req_probe = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = 16'h0015;
    for (int i = 0; i < 40; i++) begin
      if (req_ready || !busy) bad++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
    check(bad == 0, "R9 not ready while busy", bad, 0);
    check(frames == f0 + 1, "R9 no extra frame while busy", frames - f0, 1);
    check(got_addr == 8'h21 && d == mword(8'h21), "R9 held-off request has no effect",
          {got_addr, d}, {8'h21, mword(8'h21)});
  endtask

  task automatic t_done_collision();
    logic [15:0] d;
    model_aw = 8;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0000; req_probe = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_probe = 1'b0; req_addr = 16'h009E;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    check(!req_ready, "R9 not ready in response cycle", req_ready, 0);
    check(addr_wide == 1'b1, "R6 wide device detected", addr_wide, 1);
    check(d == mword(8'hFF) && got_addr == 8'hFF, "R6 probe reads address 255",
          {got_addr, d}, {8'hFF, mword(8'hFF)});
    @(negedge clk);
    check(req_ready, "R9 ready one cycle after response", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
    check(pulses_last == 27 && got_addr == 8'h9E, "R9 held request uses new width",
          {pulses_last[7:0], got_addr}, {8'd27, 8'h9E});
    check(d == mword(8'h9E), "R5 data after collision", d, mword(8'h9E));
  endtask

  initial begin
    t_reset();
    t_read_wide();
    t_upper_bits();
    t_probe_narrow();
    t_read_narrow();
    t_busy_ignore();
    t_done_collision();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule